// File: doc/BRIEF.md
# Strobed Input Port with Interrupt-Driven Byte Ring

This block takes bytes from a strobed parallel source such as a keyboard. A data-available strobe captures the byte on the input lines into a port register and raises a pending request. The pending request reaches the interrupt output only while an internal enable bit is set. Separate set and clear command inputs change that bit.

While the interrupt output is high, drain logic services the port in the same cycle. If the ring has room, the held byte is written at the write pointer, the write pointer advances with wrap-around, and the request drops. If the ring is full, the drain logic clears the enable bit instead and leaves the byte in the port register, so the byte is not lost. Software can set the enable again once the consumer has made room.

A consumer pops bytes from the read pointer. A pop on an empty ring changes nothing and produces a one-cycle underflow pulse. The two pointers have no extra wrap bit. Equal pointers mean empty, and one slot always stays unused.

Top module: `strobe_fifo_port`

## Requirements
- R1: After reset, irq_o, rd_valid_o, underflow_o and full_o are 0 and empty_o is 1. Reset clears the pointers, the port register, the request and the enable bit.
- R2: When stb_i is high at a clock edge, din_i is captured and the request is set at that edge. With the enable set, irq_o is high in the following cycle.
- R3: irq_o equals request AND enable. The request stays set until the byte is moved into the ring. With the enable clear, the byte is held and irq_o stays 0.
- R4: ien_set_i sets the enable bit at the next edge and ien_clr_i clears it. When both are high, clear wins.
- R5: In a cycle where irq_o is 1 and the ring is not full, the held byte is written at the write pointer, the write pointer advances by one modulo 2**PTR_W, and the request clears at that edge.
- R6: full_o is 1 exactly when the write pointer plus one (modulo 2**PTR_W) equals the read pointer, so the ring holds at most 2**PTR_W-1 bytes. empty_o is 1 exactly when the pointers are equal.
- R7: In a cycle where irq_o is 1 and full_o is 1, the enable clears at that edge, the byte is not stored, and the request and byte stay held. This holds even if ien_set_i is high in the same cycle.
- R8: A pop_i while empty_o is 0 presents the oldest byte on rd_data_o with rd_valid_o high in the next cycle and advances the read pointer. Bytes leave in arrival order across pointer wrap.
- R9: A pop_i while empty_o is 1 leaves the pointers unchanged and gives rd_valid_o 0 and underflow_o 1 for exactly the next cycle.
- R10: If stb_i is high in a cycle in which a drain happens, the old byte goes into the ring and the new byte is captured with the request set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stb_i | input | 1 | Data-available strobe |
| din_i | input | DATA_W | Byte presented with the strobe |
| ien_set_i | input | 1 | Set command for the interrupt enable |
| ien_clr_i | input | 1 | Clear command for the interrupt enable (wins over set) |
| irq_o | output | 1 | Interrupt request, gated by the enable |
| pop_i | input | 1 | Consumer pop request |
| rd_data_o | output | DATA_W | Popped byte |
| rd_valid_o | output | 1 | rd_data_o holds a byte popped in the previous cycle |
| underflow_o | output | 1 | One-cycle pulse after a pop on an empty ring |
| empty_o | output | 1 | Pointers equal |
| full_o | output | 1 | Write pointer one slot behind the read pointer |

## Verification
The bench fills the ring to exactly 2**PTR_W-1 bytes and strobes one more. A design that wrote that byte anyway would report empty on a full ring and lose the whole contents. A design that dropped the byte silently would show it missing after the enable is set again.

Back-to-back strobes during drains are run to catch a capture that loses either the old byte or the new one. Pops on an empty ring are run to catch a read pointer that moves anyway, which would replay stale bytes. Simultaneous set and clear commands, and a set command arriving during a full-ring block, show whether the clear wins.

// File: rtl/sqp_pkg.sv
package sqp_pkg;
  localparam int unsigned MAX_PW = 16;

  // Advance a ring pointer of width w by one with wrap-around
  function automatic logic [MAX_PW-1:0] ring_step(logic [MAX_PW-1:0] p, int unsigned w);
    logic [MAX_PW-1:0] mask;
    mask = (MAX_PW'(1) << w) - MAX_PW'(1);
    return (p + MAX_PW'(1)) & mask;
  endfunction

  // Ring is full when the write side sits one slot behind the read side
  function automatic logic ring_full(logic [MAX_PW-1:0] wp, logic [MAX_PW-1:0] rp,
                                     int unsigned w);
    return ring_step(wp, w) == rp;
  endfunction

  function automatic logic ring_empty(logic [MAX_PW-1:0] wp, logic [MAX_PW-1:0] rp);
    return wp == rp;
  endfunction
endpackage

// File: rtl/sqp_port.sv
module sqp_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ien_set_i,
  input  logic              ien_clr_i,
  input  logic              drain_i,
  input  logic              block_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              req_o,
  output logic              ien_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_o <= '0;
      req_o  <= 1'b0;
    end else if (stb_i) begin
      hold_o <= din_i;
      req_o  <= 1'b1;
    end else if (drain_i) begin
      req_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    ien_o <= 1'b0;
    else if (ien_clr_i || block_i) ien_o <= 1'b0;
    else if (ien_set_i)            ien_o <= 1'b1;
  end
endmodule

// File: rtl/sqp_ring.sv
module sqp_ring #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              uflow_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [PTR_W-1:0]  wp_o,
  output logic [PTR_W-1:0]  rp_o
);
  import sqp_pkg::*;
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic              pop_ok;

  assign empty_o = ring_empty(MAX_PW'(wp), MAX_PW'(rp));
  assign full_o  = ring_full(MAX_PW'(wp), MAX_PW'(rp), PTR_W);
  assign pop_ok  = pop_i && !empty_o;
  assign wp_o    = wp;
  assign rp_o    = rp;

  always_ff @(posedge clk) begin
    if (wr_i) mem[wp] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      uflow_o  <= 1'b0;
    end else begin
      if (wr_i) wp <= PTR_W'(ring_step(MAX_PW'(wp), PTR_W));
      if (pop_ok) begin
        rdata_o <= mem[rp];
        rp      <= PTR_W'(ring_step(MAX_PW'(rp), PTR_W));
      end
      rvalid_o <= pop_ok;
      uflow_o  <= pop_i && empty_o;
    end
  end
endmodule

// File: rtl/strobe_fifo_port.sv
module strobe_fifo_port #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ien_set_i,
  input  logic              ien_clr_i,
  output logic              irq_o,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              underflow_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [DATA_W-1:0] hold;
  logic              req, ien, drain, block;
  logic [PTR_W-1:0]  wp, rp;

  assign irq_o = req && ien;
  assign drain = irq_o && !full_o;
  assign block = irq_o && full_o;

  sqp_port #(.DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .stb_i(stb_i), .din_i(din_i),
    .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
    .drain_i(drain), .block_i(block),
    .hold_o(hold), .req_o(req), .ien_o(ien)
  );

  sqp_ring #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_i(drain), .wdata_i(hold), .pop_i(pop_i),
    .rdata_o(rd_data_o), .rvalid_o(rd_valid_o), .uflow_o(underflow_o),
    .empty_o(empty_o), .full_o(full_o), .wp_o(wp), .rp_o(rp)
  );
endmodule

// File: rtl/sqp_chk.sv
module sqp_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stb_i,
  input logic             pop_i,
  input logic             ien_clr_i,
  input logic             irq_o,
  input logic             req,
  input logic             ien,
  input logic             drain,
  input logic             full_o,
  input logic             empty_o,
  input logic             rd_valid_o,
  input logic             underflow_o,
  input logic [PTR_W-1:0] wp,
  input logic [PTR_W-1:0] rp
);
  p_stb_sets_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i |=> req);
  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !drain) |=> req);
  p_clr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr_i |=> !ien);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> !full_o);
  p_wp_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !stb_i) |=> !req);
  p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && full_o) |=> (!ien && req && $stable(wp)));
  p_pop_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !empty_o) |=> rd_valid_o);
  p_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o) |=> (underflow_o && !rd_valid_o && $stable(rp)));
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));
endmodule

bind strobe_fifo_port sqp_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb_i(stb_i), .pop_i(pop_i), .ien_clr_i(ien_clr_i),
  .irq_o(irq_o), .req(req), .ien(ien), .drain(drain), .full_o(full_o),
  .empty_o(empty_o), .rd_valid_o(rd_valid_o), .underflow_o(underflow_o),
  .wp(wp), .rp(rp)
);

// File: tb/sim_strobe_fifo_port.sv
module sim_strobe_fifo_port;
  localparam int DW = 8;
  localparam int PW = 8;
  localparam int DEPTH = 1 << PW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stb = 1'b0, set = 1'b0, clr = 1'b0, pop = 1'b0;
  logic [DW-1:0] din = '0;
  logic irq, rv, uf, empty, full;
  logic [DW-1:0] rd;

  strobe_fifo_port #(.DATA_W(DW), .PTR_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .din_i(din), .ien_set_i(set),
    .ien_clr_i(clr), .irq_o(irq), .pop_i(pop), .rd_data_o(rd),
    .rd_valid_o(rv), .underflow_o(uf), .empty_o(empty), .full_o(full)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit m_req, m_ien;
  logic [DW-1:0] m_hold;
  logic [DW-1:0] mq [DEPTH];
  int m_head, m_tail, m_cnt;
  logic [DW-1:0] last_rd;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int nxt(int i);
    return (i + 1) % DEPTH;
  endfunction

  function automatic bit m_full();
    return m_cnt == DEPTH - 1;
  endfunction

  task automatic model_clear();
    m_req = 0; m_ien = 0; m_hold = '0; m_head = 0; m_tail = 0; m_cnt = 0;
  endtask

  // One clock: drive at negedge, predict, compare at next negedge
  task automatic step(bit s, logic [DW-1:0] d, bit st, bit cl, bit p);
    bit irq_m, drain_m, block_m, pop_ok, e_uf;
    logic [DW-1:0] e_rd;
    stb = s; din = d; set = st; clr = cl; pop = p;
    irq_m   = m_req && m_ien;
    drain_m = irq_m && !m_full();
    block_m = irq_m && m_full();
    pop_ok  = p && (m_cnt != 0);
    e_uf    = p && (m_cnt == 0);
    e_rd    = mq[m_head];
    if (drain_m) begin mq[m_tail] = m_hold; m_tail = nxt(m_tail); m_cnt++; end
    if (pop_ok) begin m_head = nxt(m_head); m_cnt--; end
    if (cl || block_m) m_ien = 0; else if (st) m_ien = 1;
    if (s) begin m_hold = d; m_req = 1; end else if (drain_m) m_req = 0;
    @(posedge clk);
    @(negedge clk);
    stb = 0; set = 0; clr = 0; pop = 0;
    chk("R3", "irq", irq, m_req && m_ien);
    chk("R6", "full", full, m_full());
    chk("R6", "empty", empty, m_cnt == 0);
    chk("R8", "rd_valid", rv, pop_ok);
    chk("R9", "underflow", uf, e_uf);
    if (pop_ok) begin
      chk("R8", "rd_data", rd, e_rd);
      last_rd = rd;
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    model_clear();
    chk("R1", "irq", irq, 0);
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "rd_valid", rv, 0);
    chk("R1", "underflow", uf, 0);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    do_reset();

    // R2/R3: strobe with enable clear holds byte, no irq
    step(1, 8'h41, 0, 0, 0);
    chk("R3", "irq with enable clear", irq, 0);
    step(0, 0, 1, 0, 0);
    chk("R2", "irq after enable set", irq, 1);
    step(0, 0, 0, 0, 0);
    chk("R5", "drained, request dropped", irq, 0);
    chk("R5", "ring not empty", empty, 0);
    step(0, 0, 0, 0, 1);
    chk("R8", "popped byte", last_rd, 8'h41);
    // R9: pop on empty
    step(0, 0, 0, 0, 1);
    chk("R9", "underflow pulse", uf, 1);
    step(0, 0, 0, 0, 0);
    chk("R9", "underflow one cycle", uf, 0);
    // R4: set and clear together -> clear wins
    step(0, 0, 1, 1, 0);
    step(1, 8'h55, 0, 0, 0);
    chk("R4", "irq after set+clr", irq, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    chk("R4", "byte kept while disabled", last_rd, 8'h55);

    // R10 / R6: back-to-back strobes fill the ring to DEPTH-1
    do_reset();
    step(0, 0, 1, 0, 0);
    for (int i = 0; i < DEPTH - 1; i++) step(1, DW'(i), 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R10", "all back-to-back bytes stored, full", full, 1);
    // R7: one more byte while full, set held high in the block cycle
    step(1, 8'hEE, 0, 0, 0);
    chk("R7", "irq raised while full", irq, 1);
    step(0, 0, 1, 0, 0);
    chk("R7", "enable cleared, irq low", irq, 0);
    chk("R7", "still full, byte not stored", full, 1);
    step(0, 0, 0, 0, 1);
    chk("R8", "oldest byte first", last_rd, 8'h00);
    step(0, 0, 1, 0, 0);
    chk("R7", "held byte requests again", irq, 1);
    step(0, 0, 0, 0, 0);
    chk("R7", "held byte stored, full", full, 1);
    for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 0, 0, 1);
    chk("R7", "held byte last out", last_rd, 8'hEE);
    chk("R6", "empty after drain-out", empty, 1);

    // Random mix across pointer wrap
    do_reset();
    step(0, 0, 1, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      step(($urandom % 100) < 45, DW'($urandom), r < 4, r >= 97,
           ($urandom % 100) < 40);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule